// File: doc/BRIEF.md
# Iambic Morse Keyer with Sidetone

This block turns two paddle contacts into correctly timed Morse elements. Holding the dot paddle produces a train of short marks, and holding the dash paddle produces a train of marks three times as long. Holding both paddles alternates the two kinds of mark. Each mark is followed by a silent gap of one dot. While a mark is keyed, the block drives an active-low key line and a square-wave sidetone near 800 Hz. Between marks the key line is released and the tone is held low.

The sending speed is chosen by a small select code, which normally comes from a digitised speed knob. The code picks one of fifteen speeds from 6 to 20 words per minute, using the PARIS standard, in which a dot lasts 1.2 s divided by the speed in words per minute. The mark and gap lengths in clock cycles are constants computed when the design is elaborated. The select code is sampled only at the start of a run of marks, so a change of speed never stretches or cuts short a mark that is already sounding.

The sidetone is timed by a prescaler followed by an 8-bit counter that reloads to a fixed value and toggles the tone on each overflow. At 8 MHz, a prescale of 64 and a reload of 178, the output is a square wave of about 801 Hz. Both counters restart at the start of every mark, so each burst of tone begins with the same phase.

Top module: `morse_keyer`

## Requirements
- R1: A dot mark lasts floor(CLK_HZ*6 / (5*WPM)) clock cycles, where WPM = speed_sel + 6 for select codes 0 to 14.
- R2: A dash mark lasts exactly three dot lengths at the selected speed.
- R3: When one mark is followed directly by another, key_n is released for exactly one dot length between them.
- R4: Select codes 14 and 15 both give 20 WPM, so code 15 gives a dot of floor(CLK_HZ*6/100) cycles.
- R5: key_n is 1 during reset and whenever the keyer is idle. key_n is 0 during marks. key_n goes to 0 on the first clock edge at which an idle keyer samples a paddle as low.
- R6: While a single paddle is held, its element repeats. If the paddle is released part-way through a mark, that mark still runs to its full length and no further mark follows.
- R7: While both paddles are held, dots and dashes alternate, and each new mark is the opposite kind to the one before. If both paddles are pressed in the same cycle from idle, the dot comes first. If the dash paddle is pressed first and the dot paddle is added later, the sequence is dash, dot, dash.
- R8: speed_sel is sampled only when a run of marks starts from idle. A change while marks are being sent leaves those marks and their gaps at the old speed. The next run started from idle uses the new code.
- R9: tone is 0 whenever key_n is 1. During a mark, the tone is 0 for the first PRESCALE*(256-RELOAD) cycles and then toggles after every further PRESCALE*(256-RELOAD) cycles. This pattern restarts at every mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (8 MHz by default) |
| rst_n | input | 1 | Asynchronous reset, active low |
| dot_n | input | 1 | Dot paddle, active low, synchronous to clk |
| dash_n | input | 1 | Dash paddle, active low, synchronous to clk |
| speed_sel | input | SEL_W | Speed code; 0 to 14 give 6 to 20 WPM, and larger codes give 20 WPM |
| key_n | output | 1 | Keying line, 0 while a mark is sent |
| tone | output | 1 | Sidetone square wave, 0 outside marks |

## Verification
The keyer is driven in four ways:
- a single dot press released part-way through the mark, which checks that the mark runs to full length and that nothing repeats;
- a held single paddle, which checks repetition and the one-dot gap;
- both paddles pressed in the same cycle, which checks that the dot comes first and that the marks then alternate;
- the dash paddle pressed first with the dot paddle added later, which checks that alternation follows the last mark rather than a fixed order.

A speed change in the middle of a run tells idle-time sampling apart from live use of the select code, and code 15 checks the clamp. Randomised speeds and paddle modes then repeat these measurements of mark, gap and tone phase across the speed table.

// File: rtl/keyer_pkg.sv
package keyer_pkg;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_MARK  = 2'd1,
      KS_SPACE = 2'd2
   } key_state_t;

   // Dot length in clock cycles on the PARIS standard: 1.2 s / WPM
   function automatic int unsigned dot_cycles(input int unsigned clk_hz,
                                              input int unsigned wpm);
      longint unsigned num;
      longint unsigned den;
      num = longint'(clk_hz) * 6;
      den = longint'(wpm) * 5;
      return int'(num / den);
   endfunction

endpackage

// File: rtl/keyer_speed_rom.sv
module keyer_speed_rom import keyer_pkg::*; #(
   parameter int unsigned CLK_HZ  = 8_000_000,
   parameter int unsigned MIN_WPM = 6,
   parameter int unsigned MAX_WPM = 20,
   parameter int unsigned SEL_W   = 4,
   parameter int unsigned CNT_W   = 23
)(
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] dot_len,
   output logic [CNT_W-1:0] dash_len
);

   localparam int unsigned N_SPEEDS = MAX_WPM - MIN_WPM + 1;
   localparam int unsigned IDX_W    = (N_SPEEDS > 1) ? $clog2(N_SPEEDS) : 1;

   logic [CNT_W-1:0] dot_tab  [N_SPEEDS];
   logic [CNT_W-1:0] dash_tab [N_SPEEDS];
   logic [IDX_W-1:0] idx;

   for (genvar i = 0; i < N_SPEEDS; i++) begin : g_tab
      assign dot_tab[i]  = CNT_W'(dot_cycles(CLK_HZ, MIN_WPM + i));
      assign dash_tab[i] = CNT_W'(3 * dot_cycles(CLK_HZ, MIN_WPM + i));
   end

   // codes past the top of the table clamp to the fastest speed
   always_comb begin
      if (int'(sel) >= int'(N_SPEEDS - 1)) idx = IDX_W'(N_SPEEDS - 1);
      else                                 idx = IDX_W'(sel);
   end

   assign dot_len  = dot_tab[idx];
   assign dash_len = dash_tab[idx];

endmodule

// File: rtl/keyer_seq.sv
module keyer_seq import keyer_pkg::*; #(
   parameter int unsigned CNT_W = 23
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dot_p,
   input  logic             dash_p,
   input  logic [CNT_W-1:0] dot_len,
   input  logic [CNT_W-1:0] dash_len,
   output logic             keying,
   output logic             idle
);

   key_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] dot_q;
   logic [CNT_W-1:0] dash_q;
   logic             last_dash_q;
   logic             nxt_go;
   logic             nxt_dash;

   // choice of the element that follows a gap
   always_comb begin
      nxt_go   = dot_p | dash_p;
      if (dot_p && dash_p) nxt_dash = ~last_dash_q;
      else                 nxt_dash = ~dot_p;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= KS_IDLE;
         cnt_q       <= '0;
         dot_q       <= '0;
         dash_q      <= '0;
         last_dash_q <= 1'b0;
      end else begin
         unique case (state_q)
            KS_IDLE: begin
               if (nxt_go) begin
                  dot_q       <= dot_len;
                  dash_q      <= dash_len;
                  last_dash_q <= ~dot_p;
                  cnt_q       <= (dot_p ? dot_len : dash_len) - 1'b1;
                  state_q     <= KS_MARK;
               end
            end
            KS_MARK: begin
               if (cnt_q == '0) begin
                  cnt_q   <= dot_q - 1'b1;
                  state_q <= KS_SPACE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            KS_SPACE: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (nxt_go) begin
                  last_dash_q <= nxt_dash;
                  cnt_q       <= (nxt_dash ? dash_q : dot_q) - 1'b1;
                  state_q     <= KS_MARK;
               end else begin
                  state_q <= KS_IDLE;
               end
            end
            default: state_q <= KS_IDLE;
         endcase
      end
   end

   assign keying = (state_q == KS_MARK);
   assign idle   = (state_q == KS_IDLE);

endmodule

// File: rtl/keyer_tone_gen.sv
module keyer_tone_gen #(
   parameter int unsigned PRESCALE = 64,
   parameter int unsigned RELOAD   = 178
)(
   input  logic clk,
   input  logic rst_n,
   input  logic keying,
   output logic tone_raw
);

   localparam int unsigned PRE_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [7:0]  RELOAD_V = 8'(RELOAD);

   logic       tick;
   logic [7:0] div_q;
   logic       tone_q;

   if (PRESCALE == 1) begin : g_nopre
      assign tick = 1'b1;
   end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              pre_q <= '0;
         else if (!keying)                        pre_q <= '0;
         else if (pre_q == PRE_W'(PRESCALE - 1))  pre_q <= '0;
         else                                     pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_W'(PRESCALE - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= RELOAD_V;
         tone_q <= 1'b0;
      end else if (!keying) begin
         div_q  <= RELOAD_V;
         tone_q <= 1'b0;
      end else if (tick) begin
         if (div_q == 8'hFF) begin
            div_q  <= RELOAD_V;
            tone_q <= ~tone_q;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   assign tone_raw = tone_q;

endmodule

// File: rtl/morse_keyer.sv
module morse_keyer import keyer_pkg::*; #(
   parameter int unsigned CLK_HZ   = 8_000_000,
   parameter int unsigned MIN_WPM  = 6,
   parameter int unsigned MAX_WPM  = 20,
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned PRESCALE = 64,
   parameter int unsigned RELOAD   = 178
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dot_n,
   input  logic             dash_n,
   input  logic [SEL_W-1:0] speed_sel,
   output logic             key_n,
   output logic             tone
);

   localparam int unsigned N_SPEEDS = MAX_WPM - MIN_WPM + 1;
   localparam int unsigned MAX_MARK = 3 * dot_cycles(CLK_HZ, MIN_WPM);
   localparam int unsigned CNT_W    = $clog2(MAX_MARK + 1);

   initial begin
      assert (MIN_WPM > 0 && MAX_WPM >= MIN_WPM)
         else $error("morse_keyer: bad speed range");
      assert ((2 ** SEL_W) >= N_SPEEDS)
         else $error("morse_keyer: SEL_W too narrow for the speed table");
      assert (dot_cycles(CLK_HZ, MAX_WPM) >= 2)
         else $error("morse_keyer: clock too slow for the fastest speed");
      assert (PRESCALE >= 1 && RELOAD <= 255)
         else $error("morse_keyer: bad tone divider setting");
   end

   logic             dot_p;
   logic             dash_p;
   logic [CNT_W-1:0] dot_len;
   logic [CNT_W-1:0] dash_len;
   logic             keying;
   logic             seq_idle;
   logic             tone_raw;

   assign dot_p  = ~dot_n;
   assign dash_p = ~dash_n;

   keyer_speed_rom #(
      .CLK_HZ(CLK_HZ), .MIN_WPM(MIN_WPM), .MAX_WPM(MAX_WPM),
      .SEL_W(SEL_W), .CNT_W(CNT_W)
   ) u_rom (
      .sel(speed_sel), .dot_len(dot_len), .dash_len(dash_len)
   );

   keyer_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .dot_p(dot_p), .dash_p(dash_p),
      .dot_len(dot_len), .dash_len(dash_len),
      .keying(keying), .idle(seq_idle)
   );

   keyer_tone_gen #(.PRESCALE(PRESCALE), .RELOAD(RELOAD)) u_tone (
      .clk(clk), .rst_n(rst_n), .keying(keying), .tone_raw(tone_raw)
   );

   assign key_n = ~keying;
   assign tone  = tone_raw & keying;

endmodule

// File: rtl/morse_keyer_chk.sv
module morse_keyer_chk import keyer_pkg::*; #(
   parameter int unsigned CLK_HZ  = 8_000_000,
   parameter int unsigned MIN_WPM = 6,
   parameter int unsigned MAX_WPM = 20
)(
   input logic clk,
   input logic rst_n,
   input logic dot_n,
   input logic dash_n,
   input logic key_n,
   input logic tone,
   input logic idle
);

   localparam int unsigned MIN_DOT  = dot_cycles(CLK_HZ, MAX_WPM);
   localparam int unsigned MAX_MARK = 3 * dot_cycles(CLK_HZ, MIN_WPM);

   int unsigned lo_cnt;
   int unsigned hi_cnt;
   logic        idle_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt    <= 0;
         hi_cnt    <= 0;
         idle_seen <= 1'b1;
      end else begin
         lo_cnt    <= key_n ? 0 : lo_cnt + 1;
         hi_cnt    <= key_n ? hi_cnt + 1 : 0;
         idle_seen <= key_n ? (idle_seen | idle) : 1'b0;
      end
   end

   // R5: an idle keyer that sees a paddle keys on the next cycle
   assert_key_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && (!dot_n || !dash_n)) |=> !key_n);

   // R1 / R2: every mark lies between the fastest dot and the slowest dash
   assert_mark_bounds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_n) |-> (lo_cnt >= MIN_DOT && lo_cnt <= MAX_MARK));

   // R3: back-to-back marks are parted by at least one dot
   assert_gap_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(key_n) && !idle_seen) |-> (hi_cnt >= MIN_DOT));

   // R9: the tone is silent while the key is released
   assert_tone_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      key_n |-> !tone);

   // R9: each mark opens with the tone low
   assert_tone_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(key_n) |-> !tone);

endmodule

bind morse_keyer morse_keyer_chk #(
   .CLK_HZ(CLK_HZ), .MIN_WPM(MIN_WPM), .MAX_WPM(MAX_WPM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dot_n(dot_n), .dash_n(dash_n),
   .key_n(key_n), .tone(tone), .idle(seq_idle)
);

// File: tb/test_morse_keyer.sv
`timescale 1ns/1ps
module test_morse_keyer;

   localparam int TB_CLK_HZ = 12000;
   localparam int TB_PRE    = 4;
   localparam int TB_RELOAD = 246;
   localparam int TT        = TB_PRE * (256 - TB_RELOAD);
   localparam int WD_LIMIT  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dot_n = 1'b1;
   logic       dash_n = 1'b1;
   logic [3:0] speed_sel = 4'd0;
   logic       key_n;
   logic       tone;

   int tests = 0;
   int fails = 0;

   morse_keyer #(
      .CLK_HZ(TB_CLK_HZ), .MIN_WPM(6), .MAX_WPM(20), .SEL_W(4),
      .PRESCALE(TB_PRE), .RELOAD(TB_RELOAD)
   ) i_morse_keyer (
      .clk(clk), .rst_n(rst_n), .dot_n(dot_n), .dash_n(dash_n),
      .speed_sel(speed_sel), .key_n(key_n), .tone(tone)
   );

   always #4 clk = ~clk;

   // ---------------- expected values from the requirements ----------------
   function automatic int exp_dot(input int code);
      int wpm;
      wpm = (code > 14) ? 20 : code + 6;
      return (TB_CLK_HZ * 6) / (5 * wpm);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- port monitor ----------------
   int elem_len [128];
   int gap_len  [128];
   int n_started = 0;
   int n_done    = 0;
   int tone_bad  = 0;
   int lo_k      = 0;
   int hi_run    = 0;
   logic prev_key = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!key_n) begin
            if (prev_key) begin
               gap_len[n_started % 128] = hi_run;
               n_started++;
               lo_k = 0;
            end
            if (tone !== 1'(((lo_k / TT) % 2))) tone_bad++;
            lo_k++;
         end else begin
            if (!prev_key) begin
               elem_len[n_done % 128] = lo_k;
               n_done++;
               hi_run = 0;
            end
            if (tone !== 1'b0) tone_bad++;
            hi_run++;
         end
         prev_key = key_n;
      end
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WD_LIMIT);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // mode 0: dot, 1: dash, 2: both together, 3: dash then dot added
   task automatic run_seq(input int code, input int mode, input int n,
                          input int new_code, input string ltag);
      int base;
      int d;
      int tb0;
      base = n_started;
      tb0  = tone_bad;
      d    = exp_dot(code);
      @(negedge clk);
      speed_sel = 4'(code);
      if (mode == 0 || mode == 2) dot_n  = 1'b0;
      if (mode != 0)              dash_n = 1'b0;
      @(negedge clk);
      chk(key_n == 1'b0, "R5", "key low one cycle after press", key_n, 0);
      if (mode == 3) begin
         repeat (99) @(negedge clk);
         dot_n = 1'b0;
      end
      if (new_code >= 0) begin
         repeat (5) @(negedge clk);
         speed_sel = 4'(new_code);
      end
      while (n_started < base + n) @(posedge clk);
      @(negedge clk);
      dot_n  = 1'b1;
      dash_n = 1'b1;
      while (n_done < base + n) @(posedge clk);
      repeat (d + 20) @(posedge clk);
      chk(n_started - base == n, (mode >= 2) ? "R7" : "R6",
          "element count", n_started - base, n);
      for (int i = 0; i < n && i < 128; i++) begin
         bit    is_dash;
         int    expl;
         string tag;
         is_dash = (mode == 1) || (mode == 2 && (i % 2) == 1) ||
                   (mode == 3 && (i % 2) == 0);
         expl = is_dash ? 3 * d : d;
         if (ltag != "")   tag = ltag;
         else if (is_dash) tag = "R2";
         else              tag = "R1";
         chk(elem_len[(base + i) % 128] == expl, tag,
             is_dash ? "dash length" : "dot length",
             elem_len[(base + i) % 128], expl);
      end
      for (int i = 1; i < n; i++) begin
         chk(gap_len[(base + i) % 128] == d, "R3", "gap length",
             gap_len[(base + i) % 128], d);
      end
      chk(tone_bad == tb0, "R9", "tone pattern errors", tone_bad - tb0, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      // reset state
      repeat (4) @(negedge clk);
      chk(key_n == 1'b1, "R5", "key released in reset", key_n, 1);
      chk(tone == 1'b0, "R9", "tone low in reset", tone, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(key_n == 1'b1, "R5", "key released when idle", key_n, 1);

      run_seq(14, 0, 1, -1, "");   // R1, R6: short press, full dot, no repeat
      run_seq(0, 1, 1, -1, "");    // R2 at 6 WPM
      run_seq(15, 0, 1, -1, "R4"); // clamp
      run_seq(7, 0, 3, -1, "");    // R6 held dot repeats, R3 gaps
      run_seq(10, 2, 4, -1, "");   // R7 same-cycle: dot first, alternate
      run_seq(12, 3, 3, -1, "");   // R7 dash first, then alternate
      run_seq(14, 1, 2, 0, "R8");  // speed change mid-run ignored
      run_seq(0, 0, 1, -1, "R8");  // new speed taken from idle

      for (int it = 0; it < 5; it++) begin
         int code;
         int mode;
         int n;
         code = 6 + int'($urandom % 10);
         mode = int'($urandom % 3);
         n    = 1 + int'($urandom % 2);
         run_seq(code, mode, n, -1, "");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule